// File: doc/BRIEF.md
# Compact Instruction Parcel Decoder

This block sits between the fetch unit and the execute stage of a 32-bit processor with sixteen general registers and a 16-bit-parcel instruction encoding. It looks at the leading 16-bit parcel of an instruction and works out which of three layouts the parcel uses: a register form, a short-immediate form or a conditional-branch form. It pulls out the opcode, the register indices, the 8-bit immediate and the branch displacement. It tells the fetch logic whether a 32-bit trailing word follows, which gives a total length of 2 or 6 bytes. It flags encodings that are not defined. It also hands the execute stage a one-hot operation class and the register-write and data-memory enables.

The trailing 32-bit word, when present, is assembled by the fetch unit as a big-endian value from the four bytes after the parcel; this block only announces that it exists. A parameter chooses between a purely combinational decoder and one with an output register. In registered mode a decode is captured only when the input is marked valid, and the last decode is held otherwise.

Top module: `pcd_decoder`

## Requirements
- R1: `out_fmt` is 0 (register form) when parcel bit 15 is 0, 1 (immediate form) when bits 15:14 are 10, and 2 (branch form) when bits 15:14 are 11.
- R2: Register form: `out_opcode` = bits 15:8, `out_reg_a` = bits 7:4, `out_reg_b` = bits 3:0; `out_imm8` and `out_br_disp` are zero.
- R3: Immediate form: `out_opcode` = bits 13:12 zero-extended (0 add-immediate, 1 subtract-immediate, 2 read special register, 3 write special register), `out_reg_a` = bits 11:8, `out_imm8` = bits 7:0; `out_reg_b` and `out_br_disp` are zero.
- R4: Branch form: `out_opcode` = condition bits 13:10 zero-extended, and `out_br_disp` = bits 9:0 sign-extended to XLEN bits and multiplied by two; register and immediate outputs are zero.
- R5: `out_illegal` is 1 for register-form opcodes 0x0F to 0x18 and 0x3A to 0x7F and for branch conditions 10 to 15; every other encoding is legal.
- R6: `out_len` and `next_pc_inc` are 6 for register-form opcodes 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30, 0x36, 0x37, 0x38, 0x39, and 2 for every other parcel, illegal ones included.
- R7: For a legal parcel `out_class` has exactly one bit set: bit 0 no-operation (0x00); bit 1 arithmetic and moves (0x01, 0x02, 0x05, 0x0E, 0x1B, 0x20, 0x26 to 0x2E, add/subtract-immediate); bit 2 multiply/divide (0x2F, 0x31 to 0x34); bit 3 loads (0x07, 0x08, 0x0A, 0x0C, 0x1C, 0x1D, 0x21, 0x22, 0x36, 0x38); bit 4 stores (0x06, 0x09, 0x0B, 0x0D, 0x1E, 0x1F, 0x23, 0x24, 0x37, 0x39); bit 5 conditional branch; bit 6 jumps, calls and return (0x03, 0x04, 0x19, 0x1A, 0x25); bit 7 system (software interrupt 0x30, breakpoint 0x35, special-register read/write).
- R8: `out_reg_we` is 1 for every legal parcel except 0x00, 0x0E, 0x1A, 0x25, 0x30, 0x35, the stores other than 0x06, the write-special-register operation and all branches.
- R9: `out_mem_rd` is 1 for the loads of R7 and for 0x04; `out_mem_wr` is 1 for the stores of R7 and for 0x03 and 0x19; never both.
- R10: When `out_illegal` is 1, `out_class`, `out_reg_we`, `out_mem_rd` and `out_mem_wr` are all 0.
- R11: With OUT_REG=1, the decode of a parcel presented with `in_valid` high appears on the outputs after the next rising clock edge, `out_valid` is `in_valid` delayed by one clock, and while `in_valid` is low the previous decode is held.
- R12: With OUT_REG=1, while `rst_n` is low `out_valid` and every decode output are 0.
- R13: With OUT_REG=0, the outputs follow `in_parcel` in the same cycle and `out_valid` equals `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Parcel on `in_parcel` is to be decoded |
| in_parcel | input | 16 | Leading instruction parcel |
| out_valid | output | 1 | Decode outputs belong to a valid parcel |
| out_fmt | output | 2 | Format code |
| out_opcode | output | 8 | Opcode of the detected format |
| out_reg_a | output | 4 | First register index |
| out_reg_b | output | 4 | Second register index |
| out_imm8 | output | 8 | Unsigned short immediate |
| out_br_disp | output | XLEN | Signed branch displacement in bytes |
| out_len | output | 3 | Instruction length in bytes |
| next_pc_inc | output | 3 | Amount the fetch unit adds to its PC |
| out_illegal | output | 1 | Undefined encoding |
| out_class | output | 8 | One-hot operation class |
| out_reg_we | output | 1 | Operation writes a general register |
| out_mem_rd | output | 1 | Operation reads data memory |
| out_mem_wr | output | 1 | Operation writes data memory |

## Verification
A wrong opcode table entry shows up as a wrong class bit, enable or length for that one opcode, so every register-form opcode is applied at least once alongside random traffic. A fault in the format split corrupts fields for a whole format at once, in the same cycle in combinational mode or one clock later in registered mode. A bad capture enable in the output register shows up as outputs that move during a cycle with `in_valid` low, which the bench catches on the edge after such a cycle.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

   localparam int PARCEL_W  = 16;
   localparam int OPC_W     = 8;
   localparam int RIDX_W    = 4;
   localparam int IMM_W     = 8;
   localparam int BRF_W     = 10;
   localparam int COND_W    = 4;
   localparam int LEN_W     = 3;
   localparam int BR_COND_N = 10;
   localparam int CLS_N     = 8;

   localparam logic [LEN_W-1:0] LEN_SHORT = 3'd2;
   localparam logic [LEN_W-1:0] LEN_LONG  = 3'd6;

   // class bit positions seen by the execute stage
   localparam int CL_NOP    = 0;
   localparam int CL_ALU    = 1;
   localparam int CL_MULDIV = 2;
   localparam int CL_LOAD   = 3;
   localparam int CL_STORE  = 4;
   localparam int CL_BRANCH = 5;
   localparam int CL_FLOW   = 6;
   localparam int CL_SYS    = 7;

   typedef enum logic [1:0] {
      FMT_REG = 2'd0,
      FMT_IMM = 2'd1,
      FMT_BR  = 2'd2,
      FMT_RSV = 2'd3
   } fmt_e;

   typedef struct packed {
      logic             legal;
      logic             long_len;
      logic [CLS_N-1:0] cls;
      logic             we;
      logic             rd;
      logic             wr;
   } attr_t;

   function automatic attr_t mk_attr(input int cls_idx, input logic is_long,
                                     input logic we, input logic rd, input logic wr);
      attr_t a;
      a.legal    = 1'b1;
      a.long_len = is_long;
      a.cls      = CLS_N'(1) << cls_idx;
      a.we       = we;
      a.rd       = rd;
      a.wr       = wr;
      return a;
   endfunction

endpackage

// File: rtl/pcd_fmt_split.sv
module pcd_fmt_split
   import pcd_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [PARCEL_W-1:0] parcel,
   output fmt_e                fmt,
   output logic [OPC_W-1:0]    opcode,
   output logic [RIDX_W-1:0]   reg_a,
   output logic [RIDX_W-1:0]   reg_b,
   output logic [IMM_W-1:0]    imm8,
   output logic [XLEN-1:0]     br_disp,
   output logic [1:0]          imm_op,
   output logic [COND_W-1:0]   br_cond
);

   localparam int EXT_W = XLEN - BRF_W - 1;

   logic [BRF_W-1:0] br_field;
   logic [XLEN-1:0]  disp_full;

   assign br_field = parcel[BRF_W-1:0];

   // displacement is the field scaled by two; a generate picks whether
   // sign bits are needed above it
   generate
      if (EXT_W > 0) begin : g_sext
         assign disp_full = {{EXT_W{br_field[BRF_W-1]}}, br_field, 1'b0};
      end else begin : g_exact
         assign disp_full = {br_field, 1'b0};
      end
   endgenerate

   always_comb begin
      if (!parcel[15])     fmt = FMT_REG;
      else if (parcel[14]) fmt = FMT_BR;
      else                 fmt = FMT_IMM;

      imm_op  = parcel[13:12];
      br_cond = parcel[13:10];

      opcode  = '0;
      reg_a   = '0;
      reg_b   = '0;
      imm8    = '0;
      br_disp = '0;
      case (fmt)
         FMT_REG: begin
            opcode = parcel[15:8];
            reg_a  = parcel[7:4];
            reg_b  = parcel[3:0];
         end
         FMT_IMM: begin
            opcode = OPC_W'(imm_op);
            reg_a  = parcel[11:8];
            imm8   = parcel[7:0];
         end
         FMT_BR: begin
            opcode  = OPC_W'(br_cond);
            br_disp = disp_full;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/pcd_op_table.sv
module pcd_op_table
   import pcd_pkg::*;
(
   input  logic [OPC_W-1:0] opc,
   output attr_t            attr
);

   localparam logic Y = 1'b1;
   localparam logic N = 1'b0;

   // columns: class, trailing word, reg write, mem read, mem write
   always_comb begin
      case (opc)
         8'h00: attr = mk_attr(CL_NOP,    N, N, N, N);
         8'h01: attr = mk_attr(CL_ALU,    Y, Y, N, N);
         8'h02: attr = mk_attr(CL_ALU,    N, Y, N, N);
         8'h03: attr = mk_attr(CL_FLOW,   Y, Y, N, Y);
         8'h04: attr = mk_attr(CL_FLOW,   N, Y, Y, N);
         8'h05: attr = mk_attr(CL_ALU,    N, Y, N, N);
         8'h06: attr = mk_attr(CL_STORE,  N, Y, N, Y);
         8'h07: attr = mk_attr(CL_LOAD,   N, Y, Y, N);
         8'h08: attr = mk_attr(CL_LOAD,   Y, Y, Y, N);
         8'h09: attr = mk_attr(CL_STORE,  Y, N, N, Y);
         8'h0A: attr = mk_attr(CL_LOAD,   N, Y, Y, N);
         8'h0B: attr = mk_attr(CL_STORE,  N, N, N, Y);
         8'h0C: attr = mk_attr(CL_LOAD,   Y, Y, Y, N);
         8'h0D: attr = mk_attr(CL_STORE,  Y, N, N, Y);
         8'h0E: attr = mk_attr(CL_ALU,    N, N, N, N);
         8'h19: attr = mk_attr(CL_FLOW,   N, Y, N, Y);
         8'h1A: attr = mk_attr(CL_FLOW,   Y, N, N, N);
         8'h1B: attr = mk_attr(CL_ALU,    Y, Y, N, N);
         8'h1C: attr = mk_attr(CL_LOAD,   N, Y, Y, N);
         8'h1D: attr = mk_attr(CL_LOAD,   Y, Y, Y, N);
         8'h1E: attr = mk_attr(CL_STORE,  N, N, N, Y);
         8'h1F: attr = mk_attr(CL_STORE,  Y, N, N, Y);
         8'h20: attr = mk_attr(CL_ALU,    Y, Y, N, N);
         8'h21: attr = mk_attr(CL_LOAD,   N, Y, Y, N);
         8'h22: attr = mk_attr(CL_LOAD,   Y, Y, Y, N);
         8'h23: attr = mk_attr(CL_STORE,  N, N, N, Y);
         8'h24: attr = mk_attr(CL_STORE,  Y, N, N, Y);
         8'h25: attr = mk_attr(CL_FLOW,   N, N, N, N);
         8'h26, 8'h27, 8'h28, 8'h29, 8'h2A, 8'h2B, 8'h2C, 8'h2D, 8'h2E:
                attr = mk_attr(CL_ALU,    N, Y, N, N);
         8'h2F, 8'h31, 8'h32, 8'h33, 8'h34:
                attr = mk_attr(CL_MULDIV, N, Y, N, N);
         8'h30: attr = mk_attr(CL_SYS,    Y, N, N, N);
         8'h35: attr = mk_attr(CL_SYS,    N, N, N, N);
         8'h36: attr = mk_attr(CL_LOAD,   Y, Y, Y, N);
         8'h37: attr = mk_attr(CL_STORE,  Y, N, N, Y);
         8'h38: attr = mk_attr(CL_LOAD,   Y, Y, Y, N);
         8'h39: attr = mk_attr(CL_STORE,  Y, N, N, Y);
         default: attr = '0;
      endcase
   end

endmodule

// File: rtl/pcd_ctrl_merge.sv
module pcd_ctrl_merge
   import pcd_pkg::*;
(
   input  fmt_e              fmt,
   input  attr_t             reg_attr,
   input  logic [1:0]        imm_op,
   input  logic [COND_W-1:0] br_cond,
   output logic              illegal,
   output logic [LEN_W-1:0]  len,
   output logic [CLS_N-1:0]  cls,
   output logic              we,
   output logic              rd,
   output logic              wr
);

   attr_t sel;

   always_comb begin
      case (fmt)
         FMT_REG: sel = reg_attr;
         FMT_IMM: sel = mk_attr(imm_op[1] ? CL_SYS : CL_ALU, 1'b0,
                                (imm_op != 2'd3), 1'b0, 1'b0);
         FMT_BR:  sel = (int'(br_cond) < BR_COND_N) ?
                        mk_attr(CL_BRANCH, 1'b0, 1'b0, 1'b0, 1'b0) : '0;
         default: sel = '0;
      endcase
   end

   // one AND layer silences every side effect of an undefined encoding
   assign illegal = !sel.legal;
   assign len     = (sel.legal && sel.long_len) ? LEN_LONG : LEN_SHORT;
   assign cls     = sel.cls & {CLS_N{sel.legal}};
   assign we      = sel.we  & sel.legal;
   assign rd      = sel.rd  & sel.legal;
   assign wr      = sel.wr  & sel.legal;

endmodule

// File: rtl/pcd_decoder.sv
module pcd_decoder
   import pcd_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [PARCEL_W-1:0] in_parcel,
   output logic                out_valid,
   output logic [1:0]          out_fmt,
   output logic [OPC_W-1:0]    out_opcode,
   output logic [RIDX_W-1:0]   out_reg_a,
   output logic [RIDX_W-1:0]   out_reg_b,
   output logic [IMM_W-1:0]    out_imm8,
   output logic [XLEN-1:0]     out_br_disp,
   output logic [LEN_W-1:0]    out_len,
   output logic [LEN_W-1:0]    next_pc_inc,
   output logic                out_illegal,
   output logic [CLS_N-1:0]    out_class,
   output logic                out_reg_we,
   output logic                out_mem_rd,
   output logic                out_mem_wr
);

   generate
      if (XLEN < BRF_W + 2) begin : g_bad_xlen
         $error("pcd_decoder: XLEN too narrow for the branch displacement");
      end
   endgenerate

   fmt_e              d_fmt;
   logic [OPC_W-1:0]  d_opcode;
   logic [RIDX_W-1:0] d_reg_a;
   logic [RIDX_W-1:0] d_reg_b;
   logic [IMM_W-1:0]  d_imm8;
   logic [XLEN-1:0]   d_br_disp;
   logic [1:0]        d_imm_op;
   logic [COND_W-1:0] d_br_cond;
   attr_t             d_attr;
   logic              d_illegal;
   logic [LEN_W-1:0]  d_len;
   logic [CLS_N-1:0]  d_cls;
   logic              d_we;
   logic              d_rd;
   logic              d_wr;

   pcd_fmt_split #(.XLEN(XLEN)) u_split (
      .parcel  (in_parcel),
      .fmt     (d_fmt),
      .opcode  (d_opcode),
      .reg_a   (d_reg_a),
      .reg_b   (d_reg_b),
      .imm8    (d_imm8),
      .br_disp (d_br_disp),
      .imm_op  (d_imm_op),
      .br_cond (d_br_cond)
   );

   pcd_op_table u_table (
      .opc  (in_parcel[15:8]),
      .attr (d_attr)
   );

   pcd_ctrl_merge u_merge (
      .fmt      (d_fmt),
      .reg_attr (d_attr),
      .imm_op   (d_imm_op),
      .br_cond  (d_br_cond),
      .illegal  (d_illegal),
      .len      (d_len),
      .cls      (d_cls),
      .we       (d_we),
      .rd       (d_rd),
      .wr       (d_wr)
   );

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid   <= 1'b0;
               out_fmt     <= '0;
               out_opcode  <= '0;
               out_reg_a   <= '0;
               out_reg_b   <= '0;
               out_imm8    <= '0;
               out_br_disp <= '0;
               out_len     <= '0;
               next_pc_inc <= '0;
               out_illegal <= 1'b0;
               out_class   <= '0;
               out_reg_we  <= 1'b0;
               out_mem_rd  <= 1'b0;
               out_mem_wr  <= 1'b0;
            end else begin
               out_valid <= in_valid;
               if (in_valid) begin
                  out_fmt     <= d_fmt;
                  out_opcode  <= d_opcode;
                  out_reg_a   <= d_reg_a;
                  out_reg_b   <= d_reg_b;
                  out_imm8    <= d_imm8;
                  out_br_disp <= d_br_disp;
                  out_len     <= d_len;
                  next_pc_inc <= d_len;
                  out_illegal <= d_illegal;
                  out_class   <= d_cls;
                  out_reg_we  <= d_we;
                  out_mem_rd  <= d_rd;
                  out_mem_wr  <= d_wr;
               end
            end
         end

         AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (out_valid == $past(in_valid)));   // R11
         AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(in_valid)) |->
               $stable({out_fmt, out_opcode, out_reg_a, out_reg_b, out_imm8,
                        out_br_disp, out_len, out_class, out_illegal}));  // R11
      end else begin : g_comb
         assign out_valid   = in_valid;
         assign out_fmt     = d_fmt;
         assign out_opcode  = d_opcode;
         assign out_reg_a   = d_reg_a;
         assign out_reg_b   = d_reg_b;
         assign out_imm8    = d_imm8;
         assign out_br_disp = d_br_disp;
         assign out_len     = d_len;
         assign next_pc_inc = d_len;
         assign out_illegal = d_illegal;
         assign out_class   = d_cls;
         assign out_reg_we  = d_we;
         assign out_mem_rd  = d_rd;
         assign out_mem_wr  = d_wr;
      end
   endgenerate

   AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_illegal) |->
         (out_class == '0 && !out_reg_we && !out_mem_rd && !out_mem_wr));  // R10
   AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_illegal) |-> ($countones(out_class) == 1));  // R7
   AST_LEN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_len == LEN_SHORT || out_len == LEN_LONG) &&
                     next_pc_inc == out_len));  // R6
   AST_LONG_REG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_len == LEN_LONG) |-> (out_fmt == FMT_REG));  // R6
   AST_BR_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_fmt == FMT_BR) |->
         (out_imm8 == '0 && out_reg_a == '0 && out_reg_b == '0));  // R4
   AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_mem_rd && out_mem_wr));  // R9

endmodule

// File: tb/pcd_decoder_bench.sv
`timescale 1ns/1ps
module pcd_decoder_bench;

   localparam real CLK_HALF = 2.0;

   typedef struct packed {
      logic [1:0]  fmt;
      logic [7:0]  opc;
      logic [3:0]  ra;
      logic [3:0]  rb;
      logic [7:0]  imm;
      logic [31:0] disp;
      logic [2:0]  len;
      logic [2:0]  npc;
      logic        ill;
      logic [7:0]  cls;
      logic        we;
      logic        rd;
      logic        wr;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_parcel = '0;

   int n_chk = 0;
   int n_err = 0;
   exp_t held = '0;

   logic r_valid, r_ill, r_we, r_rd, r_wr;
   logic [1:0] r_fmt; logic [7:0] r_opc, r_imm, r_cls; logic [3:0] r_ra, r_rb;
   logic [31:0] r_disp; logic [2:0] r_len, r_npc;
   logic c_valid, c_ill, c_we, c_rd, c_wr;
   logic [1:0] c_fmt; logic [7:0] c_opc, c_imm, c_cls; logic [3:0] c_ra, c_rb;
   logic [31:0] c_disp; logic [2:0] c_len, c_npc;
   exp_t r_act, c_act;

   always #(CLK_HALF) clk = ~clk;

   pcd_decoder u_pcd_decoder (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_parcel(in_parcel),
      .out_valid(r_valid), .out_fmt(r_fmt), .out_opcode(r_opc), .out_reg_a(r_ra),
      .out_reg_b(r_rb), .out_imm8(r_imm), .out_br_disp(r_disp), .out_len(r_len),
      .next_pc_inc(r_npc), .out_illegal(r_ill), .out_class(r_cls),
      .out_reg_we(r_we), .out_mem_rd(r_rd), .out_mem_wr(r_wr));

   pcd_decoder #(.OUT_REG(1'b0)) u_pcd_decoder_comb (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_parcel(in_parcel),
      .out_valid(c_valid), .out_fmt(c_fmt), .out_opcode(c_opc), .out_reg_a(c_ra),
      .out_reg_b(c_rb), .out_imm8(c_imm), .out_br_disp(c_disp), .out_len(c_len),
      .next_pc_inc(c_npc), .out_illegal(c_ill), .out_class(c_cls),
      .out_reg_we(c_we), .out_mem_rd(c_rd), .out_mem_wr(c_wr));

   always_comb begin
      r_act = '{fmt:r_fmt, opc:r_opc, ra:r_ra, rb:r_rb, imm:r_imm, disp:r_disp,
                len:r_len, npc:r_npc, ill:r_ill, cls:r_cls, we:r_we, rd:r_rd, wr:r_wr};
      c_act = '{fmt:c_fmt, opc:c_opc, ra:c_ra, rb:c_rb, imm:c_imm, disp:c_disp,
                len:c_len, npc:c_npc, ill:c_ill, cls:c_cls, we:c_we, rd:c_rd, wr:c_wr};
   end

   function automatic exp_t model(input logic [15:0] p);
      exp_t e;
      logic [7:0] o;
      logic ld, st, lng;
      e = '0;
      e.len = 3'd2;
      if (!p[15]) begin
         o = p[15:8];
         e.fmt = 2'd0; e.opc = o; e.ra = p[7:4]; e.rb = p[3:0];
         e.ill = (o >= 8'h0F && o <= 8'h18) || (o > 8'h39);
         lng = o inside {8'h01, 8'h03, 8'h08, 8'h09, 8'h0C, 8'h0D, 8'h1A, 8'h1B, 8'h1D,
                         8'h1F, 8'h20, 8'h22, 8'h24, 8'h30, 8'h36, 8'h37, 8'h38, 8'h39};
         ld = o inside {8'h07, 8'h08, 8'h0A, 8'h0C, 8'h1C, 8'h1D, 8'h21, 8'h22, 8'h36, 8'h38};
         st = o inside {8'h06, 8'h09, 8'h0B, 8'h0D, 8'h1E, 8'h1F, 8'h23, 8'h24, 8'h37, 8'h39};
         if (o == 8'h00)                                     e.cls = 8'h01;
         else if (o inside {8'h2F, 8'h31, 8'h32, 8'h33, 8'h34}) e.cls = 8'h04;
         else if (ld)                                        e.cls = 8'h08;
         else if (st)                                        e.cls = 8'h10;
         else if (o inside {8'h03, 8'h04, 8'h19, 8'h1A, 8'h25}) e.cls = 8'h40;
         else if (o inside {8'h30, 8'h35})                   e.cls = 8'h80;
         else                                                e.cls = 8'h02;
         e.we = !(o inside {8'h00, 8'h0E, 8'h1A, 8'h25, 8'h30, 8'h35}) && !(st && o != 8'h06);
         e.rd = ld || (o == 8'h04);
         e.wr = st || (o == 8'h03) || (o == 8'h19);
         if (lng) e.len = 3'd6;
      end else if (!p[14]) begin
         e.fmt = 2'd1; e.opc = {6'b0, p[13:12]}; e.ra = p[11:8]; e.imm = p[7:0];
         e.cls = p[13] ? 8'h80 : 8'h02;
         e.we = (p[13:12] != 2'd3);
      end else begin
         e.fmt = 2'd2; e.opc = {4'b0, p[13:10]};
         e.disp = {{21{p[9]}}, p[9:0], 1'b0};
         e.ill = (p[13:10] > 4'd9);
         e.cls = 8'h20;
      end
      if (e.ill) begin
         e.cls = '0; e.we = 1'b0; e.rd = 1'b0; e.wr = 1'b0; e.len = 3'd2;
      end
      e.npc = e.len;
      return e;
   endfunction

   task automatic cmp(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic check_vec(input string mode, input exp_t a, input exp_t e);
      string ft;
      ft = (e.fmt == 2'd0) ? "R2" : ((e.fmt == 2'd1) ? "R3" : "R4");
      cmp("R1", {mode, " fmt"}, 32'(a.fmt), 32'(e.fmt));
      cmp(ft, {mode, " opcode"}, 32'(a.opc), 32'(e.opc));
      cmp(ft, {mode, " reg_a"}, 32'(a.ra), 32'(e.ra));
      cmp(ft, {mode, " reg_b"}, 32'(a.rb), 32'(e.rb));
      cmp(ft, {mode, " imm8"}, 32'(a.imm), 32'(e.imm));
      cmp(ft, {mode, " br_disp"}, a.disp, e.disp);
      cmp("R5", {mode, " illegal"}, 32'(a.ill), 32'(e.ill));
      cmp("R6", {mode, " len"}, 32'(a.len), 32'(e.len));
      cmp("R6", {mode, " next_pc_inc"}, 32'(a.npc), 32'(e.npc));
      cmp(e.ill ? "R10" : "R7", {mode, " class"}, 32'(a.cls), 32'(e.cls));
      cmp(e.ill ? "R10" : "R8", {mode, " reg_we"}, 32'(a.we), 32'(e.we));
      cmp(e.ill ? "R10" : "R9", {mode, " mem_rd"}, 32'(a.rd), 32'(e.rd));
      cmp(e.ill ? "R10" : "R9", {mode, " mem_wr"}, 32'(a.wr), 32'(e.wr));
   endtask

   task automatic apply(input logic [15:0] p, input logic v);
      exp_t e;
      e = model(p);
      @(negedge clk);
      in_parcel = p;
      in_valid  = v;
      #1;
      cmp("R13", "comb out_valid", 32'(c_valid), 32'(v));
      check_vec("comb R13", c_act, e);
      @(posedge clk);
      #1;
      cmp("R11", "reg out_valid", 32'(r_valid), 32'(v));
      if (v) begin
         check_vec("reg R11", r_act, e);
         held = e;
      end else begin
         check_vec("hold R11", r_act, held);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #(CLK_HALF * 2.0 * 200000.0);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int unsigned seed_init;
      seed_init = $urandom(32'd20240611);

      // R12: reset holds every registered output at zero
      in_valid  = 1'b1;
      in_parcel = 16'h0153;
      repeat (3) @(posedge clk);
      #1;
      cmp("R12", "reset out_valid", 32'(r_valid), 32'd0);
      n_chk++;
      if (r_act !== '0) begin
         n_err++;
         $display("FAIL R12 reset outputs: actual=%h expected=0", r_act);
      end
      @(negedge clk);
      rst_n    = 1'b1;
      in_valid = 1'b0;

      // R11: idle before any valid parcel keeps the reset values
      apply(16'h2F45, 1'b0);

      // every register-form opcode (R2, R5, R6, R7, R8, R9)
      for (int i = 0; i < 128; i++) begin
         apply({i[7:0], 8'($urandom())}, 1'b1);
      end

      // immediate form operations (R3)
      for (int i = 0; i < 4; i++) begin
         apply({2'b10, i[1:0], 4'($urandom()), 8'($urandom())}, 1'b1);
      end

      // branch conditions with offset extremes (R4, R5)
      for (int i = 0; i < 16; i++) begin
         logic [9:0] off;
         case (i % 4)
            0: off = 10'h000;
            1: off = 10'h1FF;
            2: off = 10'h200;
            default: off = 10'h3FF;
         endcase
         apply({2'b11, i[3:0], off}, 1'b1);
      end

      // hold while in_valid is low (R11)
      apply(16'h0D12, 1'b1);
      apply(16'hC3FF, 1'b0);
      apply(16'h9ABC, 1'b0);
      apply(16'h1000, 1'b1);
      apply(16'h0000, 1'b0);

      // random traffic
      for (int i = 0; i < 1500; i++) begin
         apply(16'($urandom()), ($urandom() % 4) != 0);
      end

      finish_run();
   end

endmodule